// File: doc/BRIEF.md
# Four-Bit Indirect Register Port for a Quad Line Feeder

This block is the microprocessor side of a four-channel line feed controller. A host reaches it over a narrow four-bit bus made of one address bit, an address strobe, an active-low select, active-low read and write strobes and a data path split into an input half, an output half and an output-enable. The bus is asynchronous to the block. Every bus pin is brought into the block clock through a two-stage synchronizer, and a write takes effect on the rising edge of the write strobe.

Two registers are writable. The first holds a three-bit group selector and an interrupt enable. The second holds a per-channel on/off request. The request register is not applied straight to the lines. A separate per-channel accept input, driven by the thermal and sequencing logic outside this block, copies request bits into the line control register, and that register drives the channel switches. Reads with the address bit low return the selector together with an over-temperature flag. Reads with the address bit high return one status group for all four channels, chosen by the selector.

An active-low interrupt output follows the channel overload bits whenever the interrupt enable is set. It is not latched. The analog status bits and the thermal flag arrive as inputs that are already in the block clock domain.

Top module: `lfc_mpu_port`

## Requirements
- R1: The effective address bit follows `a0` while `ale` is high and holds the value present when `ale` fell; with `ale` held high the bus behaves as non-multiplexed.
- R2: While `cs_n` is high, `data_oe` stays low and write strobes change no register.
- R3: A write with address 0 loads data bits 2..0 into the group selector and data bit 3 into the interrupt enable.
- R4: A write with address 1 loads data bits 3..0 into the request register; bit n requests channel n on (1) or off (0).
- R5: A read with address 0 returns the group selector on bits 2..0 and the `ovtemp` input on bit 3. It does not return the interrupt enable.
- R6: A read with address 1 returns bit n of the group for channel n. The selector picks the group: 000 `pof`, 001 `old`, 010 `cod`, 011 line control register, 110 request register, 111 `tor`.
- R7: Selector codes 100 and 101 read as 0000.
- R8: `int_n` is low exactly when the interrupt enable is 1 and at least one `cod` bit is 1. It is combinational and returns high as soon as all `cod` bits clear.
- R9: On a clock edge where `lec_load[n]` is high, line control bit n takes request bit n. In every other case line control bit n holds its value.
- R10: After reset the selector, interrupt enable, request register and line control register are all zero, `int_n` is high and `data_oe` is low.
- R11: The data stored by a write is the value present at the rising edge of `wr_n`. Earlier values seen while the strobe was low do not count.
- R12: `data_oe` is high only while `cs_n` and `rd_n` are both low and `wr_n` is high, after synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch strobe; the latch is transparent while high |
| a0 | input | 1 | Address bit selecting the register |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| data_in | input | 4 | Bus data from the host |
| data_out | output | 4 | Bus data to the host, zero when not driven |
| data_oe | output | 1 | High when the block drives the bus |
| pof | input | 4 | Per-channel power-on flags |
| old | input | 4 | Per-channel open-loop flags |
| cod | input | 4 | Per-channel current-overload flags |
| tor | input | 4 | Per-channel thermal permission flags |
| ovtemp | input | 1 | Chip over-temperature flag |
| lec_load | input | 4 | Per-channel accept strobe copying a request bit into line control |
| ler | output | 4 | Request register contents |
| lec | output | 4 | Line control register driving the channel switches |
| int_n | output | 1 | Active-low interrupt |

## Verification
The address latch is the hardest behaviour to reach from the ports, because its effect shows only when the access happens after `ale` has fallen and `a0` has moved on. Every bench access therefore latches the intended address, pulls `ale` low and then drives the opposite value on `a0` before asserting select. A separate pass holds `ale` high to cover transparent operation. The rising-edge capture rule is reached by changing the data in the middle of a write strobe. The accept path is exercised by loading request values and pulsing partial `lec_load` masks, with the result checked on both `lec` and a selector 011 read.

// File: rtl/lfc_mpu_pkg.sv
package lfc_mpu_pkg;

  // Status group selector codes; bit n of each group is channel n.
  typedef enum logic [2:0] {
    GRP_POF  = 3'b000,
    GRP_OLD  = 3'b001,
    GRP_COD  = 3'b010,
    GRP_LEC  = 3'b011,
    GRP_RSV4 = 3'b100,
    GRP_RSV5 = 3'b101,
    GRP_LER  = 3'b110,
    GRP_TOR  = 3'b111
  } grp_sel_e;

  // Address-0 readback: thermal flag on the top bit, selector below it.
  function automatic logic [3:0] iar_readback(logic t_flag, logic [2:0] code);
    return {t_flag, code};
  endfunction

  function automatic logic sel_reserved(grp_sel_e s);
    return (s == GRP_RSV4) || (s == GRP_RSV5);
  endfunction

endpackage

// File: rtl/lfc_sync.sv
module lfc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/lfc_bus_decode.sv
module lfc_bus_decode #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale_s,
  input  logic           a0_s,
  input  logic           cs_n_s,
  input  logic           rd_n_s,
  input  logic           wr_n_s,
  input  logic [NCH-1:0] d_s,
  output logic           addr_eff,
  output logic           rd_en,
  output logic           wr_pulse,
  output logic           wr_iar,
  output logic           wr_ler,
  output logic [NCH-1:0] wdata
);

  logic           a0_hold;
  logic           wr_n_q;
  logic           cs_n_q;
  logic           addr_q;
  logic [NCH-1:0] d_q;

  // Address latch: open while ale is high, closed on its fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     a0_hold <= 1'b0;
    else if (ale_s) a0_hold <= a0_s;
  end

  assign addr_eff = ale_s ? a0_s : a0_hold;

  // One-cycle history so the write sees the bus as it stood at release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      cs_n_q <= 1'b1;
      addr_q <= 1'b0;
      d_q    <= '0;
    end else begin
      wr_n_q <= wr_n_s;
      cs_n_q <= cs_n_s;
      addr_q <= addr_eff;
      d_q    <= d_s;
    end
  end

  assign wr_pulse = wr_n_s & ~wr_n_q & ~cs_n_q;
  assign wr_iar   = wr_pulse & ~addr_q;
  assign wr_ler   = wr_pulse &  addr_q;
  assign wdata    = d_q;
  assign rd_en    = ~cs_n_s & ~rd_n_s & wr_n_s;

  // R11: a strobe release yields exactly one write event
  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R1: with ale low the latched address does not move
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && !$past(ale_s)) |-> $stable(a0_hold));

endmodule

// File: rtl/lfc_regs.sv
module lfc_regs #(
  parameter int NCH = 4,
  localparam int SELW = NCH - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_iar,
  input  logic            wr_ler,
  input  logic [NCH-1:0]  wdata,
  input  logic [NCH-1:0]  lec_load,
  output logic [SELW-1:0] iar_code,
  output logic            int_en,
  output logic [NCH-1:0]  ler_q,
  output logic [NCH-1:0]  lec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iar_code <= '0;
      int_en   <= 1'b0;
    end else if (wr_iar) begin
      iar_code <= wdata[SELW-1:0];
      int_en   <= wdata[NCH-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ler_q <= '0;
    else if (wr_ler) ler_q <= wdata;
  end

  // Per-channel accept: only the outside supervisor moves a line.
  for (genvar n = 0; n < NCH; n++) begin : g_lec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           lec_q[n] <= 1'b0;
      else if (lec_load[n]) lec_q[n] <= ler_q[n];
    end
  end

  assert_lec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lec_load == '0) |=> $stable(lec_q));

  assert_ler_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ler |=> $stable(ler_q));

  assert_iar_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_iar |=> ($stable(iar_code) && $stable(int_en)));

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_iar && wr_ler));

endmodule

// File: rtl/lfc_mpu_port.sv
module lfc_mpu_port
  import lfc_mpu_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ale,
  input  logic           a0,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [NCH-1:0] data_in,
  output logic [NCH-1:0] data_out,
  output logic           data_oe,
  input  logic [NCH-1:0] pof,
  input  logic [NCH-1:0] old,
  input  logic [NCH-1:0] cod,
  input  logic [NCH-1:0] tor,
  input  logic           ovtemp,
  input  logic [NCH-1:0] lec_load,
  output logic [NCH-1:0] ler,
  output logic [NCH-1:0] lec,
  output logic           int_n
);

  localparam int SELW = NCH - 1;
  localparam int IW   = NCH + 5;
  localparam logic [IW-1:0] BUS_IDLE = {5'b00111, {NCH{1'b0}}};

  logic [IW-1:0]   bus_raw, bus_s;
  logic            ale_s, a0_s, cs_n_s, rd_n_s, wr_n_s;
  logic [NCH-1:0]  d_s;
  logic            addr_eff, rd_en, wr_pulse, wr_iar, wr_ler;
  logic [NCH-1:0]  wdata;
  logic [SELW-1:0] iar_code;
  logic            int_en;
  logic [NCH-1:0]  rd_word;
  grp_sel_e        grp;

  assign bus_raw = {ale, a0, cs_n, rd_n, wr_n, data_in};

  lfc_sync #(.W(IW), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (bus_raw), .dout (bus_s)
  );

  assign {ale_s, a0_s, cs_n_s, rd_n_s, wr_n_s, d_s} = bus_s;

  lfc_bus_decode #(.NCH(NCH)) u_dec (
    .clk (clk), .rst_n (rst_n),
    .ale_s (ale_s), .a0_s (a0_s), .cs_n_s (cs_n_s), .rd_n_s (rd_n_s),
    .wr_n_s (wr_n_s), .d_s (d_s),
    .addr_eff (addr_eff), .rd_en (rd_en), .wr_pulse (wr_pulse),
    .wr_iar (wr_iar), .wr_ler (wr_ler), .wdata (wdata)
  );

  lfc_regs #(.NCH(NCH)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .wr_iar (wr_iar), .wr_ler (wr_ler), .wdata (wdata), .lec_load (lec_load),
    .iar_code (iar_code), .int_en (int_en), .ler_q (ler), .lec_q (lec)
  );

  assign grp = grp_sel_e'(iar_code);

  always_comb begin
    rd_word = '0;
    if (!addr_eff) begin
      rd_word = iar_readback(ovtemp, iar_code);
    end else begin
      case (grp)
        GRP_POF: rd_word = pof;
        GRP_OLD: rd_word = old;
        GRP_COD: rd_word = cod;
        GRP_LEC: rd_word = lec;
        GRP_LER: rd_word = ler;
        GRP_TOR: rd_word = tor;
        default: rd_word = '0;
      endcase
    end
  end

  assign data_oe  = rd_en;
  assign data_out = rd_en ? rd_word : '0;
  assign int_n    = ~(int_en & (|cod));

  assert_int_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> int_n);

  assert_int_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (|cod));

  assert_drive_needs_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!cs_n_s && !rd_n_s));

  assert_no_write_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n_s) && cs_n_s) |-> !wr_pulse);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && addr_eff && sel_reserved(grp)) |-> (data_out == '0));

endmodule

// File: tb/lfc_mpu_port_test.sv
module lfc_mpu_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, a0 = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] data_in = '0;
  logic [3:0] data_out;
  logic       data_oe;
  logic [3:0] pof = '0, old = '0, cod = '0, tor = '0, lec_load = '0;
  logic       ovtemp = 1'b0;
  logic [3:0] ler, lec;
  logic       int_n;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  bit ale_tied = 0;

  always #4 clk = ~clk;

  lfc_mpu_port uut (
    .clk (clk), .rst_n (rst_n), .ale (ale), .a0 (a0), .cs_n (cs_n),
    .rd_n (rd_n), .wr_n (wr_n), .data_in (data_in), .data_out (data_out),
    .data_oe (data_oe), .pof (pof), .old (old), .cod (cod), .tor (tor),
    .ovtemp (ovtemp), .lec_load (lec_load), .ler (ler), .lec (lec),
    .int_n (int_n)
  );

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Latch address then scramble a0, unless ale is tied high.
  task automatic set_addr(logic a);
    a0 = a;
    if (!ale_tied) begin
      ale = 1'b1; idle(4); ale = 1'b0; idle(4); a0 = ~a;
    end else begin
      idle(4);
    end
  endtask

  task automatic bus_write(logic a, logic [3:0] d);
    set_addr(a);
    data_in = d; cs_n = 1'b0; wr_n = 1'b0; idle(4);
    wr_n = 1'b1; idle(4);
    cs_n = 1'b1; idle(4);
  endtask

  task automatic bus_read(logic a, output logic [3:0] d, output logic oe);
    set_addr(a);
    cs_n = 1'b0; rd_n = 1'b0; idle(5);
    d = data_out; oe = data_oe;
    rd_n = 1'b1; cs_n = 1'b1; idle(4);
  endtask

  function automatic logic [3:0] expect_group(int code, logic [3:0] g_pof, logic [3:0] g_old,
      logic [3:0] g_cod, logic [3:0] g_lec, logic [3:0] g_ler, logic [3:0] g_tor);
    logic [3:0] groups [8];
    groups[0] = g_pof; groups[1] = g_old; groups[2] = g_cod; groups[3] = g_lec;
    groups[4] = 4'h0;  groups[5] = 4'h0;  groups[6] = g_ler; groups[7] = g_tor;
    return groups[code];
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    logic       oe;
    logic [3:0] lec_model;
    logic [3:0] ler_model;

    cod = 4'hF;
    idle(3);
    // R10: reset state visible at the ports
    check("R10 lec", lec, 4'h0);
    check("R10 ler", ler, 4'h0);
    check("R10 int_n", {3'b0, int_n}, 4'h1);
    check("R10 oe", {3'b0, data_oe}, 4'h0);
    rst_n = 1'b1;
    idle(4);
    bus_read(1'b0, rd, oe);
    check("R10 iar read", rd, 4'h0);
    check("R12 oe on read", {3'b0, oe}, 4'h1);
    cod = 4'h0;

    // R3/R5: every selector, interrupt enable and thermal flag
    for (int code = 0; code < 8; code++) begin
      for (int t = 0; t < 2; t++) begin
        ovtemp = t[0];
        bus_write(1'b0, {~t[0], code[2:0]});
        bus_read(1'b0, rd, oe);
        check("R5 iar readback", rd, {t[0], code[2:0]});
        cod = 4'h2; idle(1);
        check("R3 enable via bit3", {3'b0, int_n}, {3'b0, t[0]});
        cod = 4'h0; idle(1);
      end
    end
    ovtemp = 1'b0;

    // R8: interrupt over all overload patterns and both enables
    for (int en = 0; en < 2; en++) begin
      bus_write(1'b0, {en[0], 3'b000});
      for (int c = 0; c < 16; c++) begin
        cod = c[3:0]; idle(1);
        check("R8 int_n", {3'b0, int_n}, {3'b0, ~(en[0] && (c != 0))});
      end
    end
    cod = 4'h0; idle(1);
    check("R8 unlatched release", {3'b0, int_n}, 4'h1);
    bus_write(1'b0, 4'h0);

    // R4/R9: request loads and partial accept masks
    lec_model = 4'h0;
    for (int v = 0; v < 16; v++) begin
      bus_write(1'b1, v[3:0]);
      ler_model = v[3:0];
      check("R4 ler port", ler, ler_model);
      check("R9 lec holds", lec, lec_model);
      lec_load = 4'(v * 5 + 3); @(negedge clk);
      lec_model = (lec_model & ~lec_load) | (ler_model & lec_load);
      lec_load = 4'h0; idle(2);
      check("R9 lec masked copy", lec, lec_model);
    end

    // R6/R7: sweep selectors against status patterns
    for (int code = 0; code < 8; code++) begin
      bus_write(1'b0, {1'b0, code[2:0]});
      for (int p = 0; p < 16; p += 3) begin
        pof = p[3:0]; old = p[3:0] ^ 4'h5;
        cod = {p[0], p[3:1]}; tor = ~p[3:0];
        bus_read(1'b1, rd, oe);
        if (code == 4 || code == 5)
          check("R7 reserved reads zero", rd, 4'h0);
        else
          check("R6 status group", rd,
                expect_group(code, pof, old, cod, lec_model, ler_model, tor));
      end
    end
    cod = 4'h0;

    // R2: unselected strobe does not write, bus not driven
    bus_write(1'b1, 4'h9);
    ler_model = 4'h9;
    set_addr(1'b1);
    data_in = 4'h6; wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(6);
    check("R2 ler untouched", ler, ler_model);
    rd_n = 1'b0; idle(5);
    check("R2 oe with cs high", {3'b0, data_oe}, 4'h0);
    rd_n = 1'b1; idle(4);

    // R12: read and write strobes both low: not driven
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; data_in = 4'h9; idle(5);
    check("R12 oe during write", {3'b0, data_oe}, 4'h0);
    rd_n = 1'b1; wr_n = 1'b1; idle(4); cs_n = 1'b1; idle(4);

    // R11: data changed mid-strobe, last value wins
    set_addr(1'b1);
    data_in = 4'h3; cs_n = 1'b0; wr_n = 1'b0; idle(4);
    data_in = 4'hC; idle(4);
    wr_n = 1'b1; idle(4); cs_n = 1'b1; idle(4);
    check("R11 edge capture", ler, 4'hC);

    // R1: transparent latch with ale tied high
    ale_tied = 1; ale = 1'b1;
    bus_write(1'b1, 4'h5);
    check("R1 tied ale write A1", ler, 4'h5);
    bus_write(1'b0, 4'b0110);
    bus_read(1'b1, rd, oe);
    check("R1 tied ale read A1", rd, 4'h5);
    bus_read(1'b0, rd, oe);
    check("R1 tied ale read A0", rd, 4'b0110);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule